// File: doc/BRIEF.md
# Split Serial Access Register Controller

This block manages a 512-word, 16-bit serial access register that feeds one DRAM row to a video pipeline a word at a time. A full load copies a whole row into the register in one cycle. A split load refills only the half that is not being read, so the stream never has to stop for a reload. Every load also sets a start position, the tap. Each serial step presents the word under the pointer and then moves the pointer on. When a split load is pending, the pointer jumps to the pending tap at the next boundary.

The register can be cut into equal partitions of 32, 64, 128 or 256 words. The last word of each partition is a boundary where a pending jump may happen. The last word of each half is always such a boundary. A half-status flag reports which half the pointer is in. The serial word and the flag are driven only while the active-low serial enable is asserted. When serial enable is high, both are zero and their output enables are low, which stands in for high impedance. The serial clock is a one-cycle step strobe in the block's clock domain. All commands are one-cycle pulses.

Top module: `ssr_ctrl`

## Requirements
- R1: After reset the pointer is 0 and the presented word is 0. The half-status is 0, no split load is pending, and partitions are 256 words.
- R2: A full load copies row word i into register word i for every i. It sets the pointer to the 9-bit tap and the half-status to tap bit 8, and it cancels any pending split load. The presented word does not change until the next step.
- R3: A step presents the register word at the pointer one cycle later and then advances the pointer, wrapping from 511 to 0. The first step after a load therefore presents the tap word.
- R4: A split load writes the 256 words of the row half selected by tap bit 8 into the register half the pointer is not in. The pending tap is that half combined with tap bits 7:0. A split load by itself leaves the pointer and the half-status unchanged.
- R5: When a step finds the pointer on a boundary (a partition end, or word 255 or 511) and a split load is pending, the pointer moves to the pending tap and the pending load is consumed.
- R6: With nothing pending, the pointer increments through boundaries. The half-status always equals bit 8 of the pointer, so it toggles when the pointer crosses between halves.
- R7: A stop-point set command with code 0, 1, 2 or 3 selects partitions of 32, 64, 128 or 256 words. The new size takes effect from the next cycle.
- R8: An option-reset command restores 256-word partitions. It wins over a stop-point set in the same cycle.
- R9: While serial enable is high, the serial word and half-status read 0 and both enables are low. Steps and loads still act normally.
- R10: A full load wins over a step or a split load in the same cycle. The step presents nothing and the split load is dropped.
- R11: A step and a split load in the same cycle behave as follows. The step reads the old contents and consumes the old pending tap. The split load targets the half opposite the pointer after the step, and its tap replaces any pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_full | input | 1 | Full row load pulse |
| xfer_split | input | 1 | Half row load pulse |
| xfer_addr | input | 9 | Tap; bit 8 also picks the source half of a split load |
| row_bus | input | 8192 | Parallel row, word i at bits 16*i+15:16*i |
| sp_set | input | 1 | Stop-point set pulse |
| sp_code | input | 2 | Partition size code (32 << code words) |
| opt_reset | input | 1 | Option-reset pulse, restores 256-word partitions |
| sc_step | input | 1 | Serial clock rising-edge strobe |
| se_n | input | 1 | Serial enable, active low |
| sq_out | output | 16 | Presented serial word |
| sq_oe | output | 1 | Serial word drive enable |
| qsf_out | output | 1 | Half-status flag (1 = upper half) |
| qsf_oe | output | 1 | Half-status drive enable |

## Verification
The delicate overlap is a serial step landing on a half or partition boundary in the same cycle as a split load. In that cycle the step decides whether to jump or to increment, and the split load picks its destination half from where the step leaves the pointer. The bench provokes this on purpose: it parks the pointer on word 255, then issues a step and a split load together, and later walks the pointer to the far boundary to see where it jumps. A long random phase also overlaps steps with loads and size changes. A behavioural model, kept as plain arrays and integers, predicts every output on every cycle.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int SSR_WORD_W        = 16;
    localparam int SSR_DEPTH         = 512;
    localparam int SSR_MIN_PART_LOG2 = 5;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_FULL  = 2'd1,
        XF_SPLIT = 2'd2
    } xfer_e;

    // A full load outranks a split load issued in the same cycle.
    function automatic xfer_e xfer_decode(input logic full, input logic split);
        if (full)
            return XF_FULL;
        else if (split)
            return XF_SPLIT;
        return XF_IDLE;
    endfunction

endpackage

// File: rtl/ssr_stopcfg.sv
module ssr_stopcfg #(
    parameter int HALF_AW  = 8,
    parameter int MIN_LOG2 = 5,
    parameter int CODE_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sp_set,
    input  logic [CODE_W-1:0]  sp_code,
    input  logic               opt_reset,
    output logic [HALF_AW-1:0] part_mask
);
    localparam int MAX_CODE = HALF_AW - MIN_LOG2;

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_in;

    always_comb begin
        if (int'(sp_code) > MAX_CODE)
            code_in = CODE_W'(MAX_CODE);
        else
            code_in = sp_code;
    end

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= CODE_W'(MAX_CODE);
        else if (opt_reset)
            code_q <= CODE_W'(MAX_CODE);
        else if (sp_set)
            code_q <= code_in;
    end

    // Mask of in-partition offset bits: a position is a stop point when all are set.
    for (genvar b = 0; b < HALF_AW; b++) begin : g_mask
        assign part_mask[b] = (int'(code_q) + MIN_LOG2) > b;
    end

    // R8
    opt_reset_restores_chk: assert property (@(posedge clk) disable iff (rst)
        opt_reset |=> (part_mask == '1));

    // R7
    stop_len_chk: assert property (@(posedge clk) disable iff (rst)
        (sp_set && !opt_reset && int'(sp_code) <= MAX_CODE)
        |=> ($countones(part_mask) == MIN_LOG2 + int'($past(sp_code))));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sp_set && !opt_reset) |=> $stable(part_mask));

endmodule

// File: rtl/ssr_ptr.sv
module ssr_ptr
    import ssr_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_e         xfer,
    input  logic [AW-1:0] xfer_addr,
    input  logic          step,
    input  logic [AW-2:0] part_mask,
    output logic [AW-1:0] ptr_q,
    output logic          qsf_q,
    output logic          rd_fire,
    output logic          split_fire,
    output logic          split_dst_half
);
    localparam int HB = AW - 1;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] tap;
    } pend_t;

    pend_t         pend_q;
    logic          adv;
    logic          at_stop;
    logic          jump;
    logic [AW-1:0] ptr_nx;

    always_comb begin
        adv     = step && (xfer != XF_FULL);
        at_stop = (ptr_q[HB-1:0] & part_mask) == part_mask;
        jump    = adv && at_stop && pend_q.valid;
        if (jump)
            ptr_nx = pend_q.tap;
        else if (adv)
            ptr_nx = ptr_q + AW'(1);
        else
            ptr_nx = ptr_q;
    end

    assign rd_fire        = adv;
    assign split_fire     = (xfer == XF_SPLIT);
    // The refill goes to the half the pointer is not in after this cycle's step.
    assign split_dst_half = ~ptr_nx[HB];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            qsf_q  <= 1'b0;
            pend_q <= '0;
        end else if (xfer == XF_FULL) begin
            ptr_q  <= xfer_addr;
            qsf_q  <= xfer_addr[HB];
            pend_q <= '0;
        end else begin
            ptr_q <= ptr_nx;
            if (adv)
                qsf_q <= ptr_nx[HB];
            if (split_fire) begin
                pend_q.valid <= 1'b1;
                pend_q.tap   <= {split_dst_half, xfer_addr[HB-1:0]};
            end else if (jump) begin
                pend_q.valid <= 1'b0;
            end
        end
    end

    // R5
    pend_other_half_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q.valid |-> (pend_q.tap[HB] != ptr_q[HB]));

    // R5
    jump_lands_chk: assert property (@(posedge clk) disable iff (rst)
        jump |=> (ptr_q == $past(pend_q.tap)));

    // R2
    full_tap_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer == XF_FULL) |=> (ptr_q == $past(xfer_addr) && !pend_q.valid));

    // R6
    qsf_follows_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        qsf_q == ptr_q[HB]);

    // R4
    split_holds_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer == XF_SPLIT && !step) |=> ($stable(ptr_q) && $stable(qsf_q)));

endmodule

// File: rtl/ssr_store.sv
module ssr_store #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 512
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_full,
    input  logic                    load_split,
    input  logic                    dst_half,
    input  logic                    src_half,
    input  logic [DEPTH*WORD_W-1:0] row_bus,
    input  logic                    rd_fire,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WORD_W-1:0]       word_q
);
    localparam int AW   = $clog2(DEPTH);
    localparam int HALF = DEPTH / 2;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
            word_q <= '0;
        end else begin
            // Read uses the contents from before this cycle's write.
            if (rd_fire)
                word_q <= mem[rd_addr];
            if (load_full) begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] <= row_bus[i*WORD_W +: WORD_W];
            end else if (load_split) begin
                for (int i = 0; i < HALF; i++)
                    mem[{dst_half, (AW-1)'(i)}] <=
                        row_bus[int'({src_half, (AW-1)'(i)})*WORD_W +: WORD_W];
            end
        end
    end

    // R10
    no_read_on_full_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_fire && load_full));

    // R10
    one_load_kind_chk: assert property (@(posedge clk) disable iff (rst)
        !(load_full && load_split));

endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
    import ssr_pkg::*;
#(
    parameter int WORD_W        = SSR_WORD_W,
    parameter int DEPTH         = SSR_DEPTH,
    parameter int MIN_PART_LOG2 = SSR_MIN_PART_LOG2,
    localparam int AW           = $clog2(DEPTH),
    localparam int HALF_AW      = AW - 1,
    localparam int CODE_W       = $clog2(HALF_AW - MIN_PART_LOG2 + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    xfer_full,
    input  logic                    xfer_split,
    input  logic [AW-1:0]           xfer_addr,
    input  logic [DEPTH*WORD_W-1:0] row_bus,
    input  logic                    sp_set,
    input  logic [CODE_W-1:0]       sp_code,
    input  logic                    opt_reset,
    input  logic                    sc_step,
    input  logic                    se_n,
    output logic [WORD_W-1:0]       sq_out,
    output logic                    sq_oe,
    output logic                    qsf_out,
    output logic                    qsf_oe
);
    xfer_e              xfer;
    logic [HALF_AW-1:0] part_mask;
    logic [AW-1:0]      ptr_q;
    logic               qsf_q;
    logic               rd_fire;
    logic               split_fire;
    logic               split_dst_half;
    logic [WORD_W-1:0]  word_q;

    assign xfer = xfer_decode(xfer_full, xfer_split);

    ssr_stopcfg #(
        .HALF_AW  (HALF_AW),
        .MIN_LOG2 (MIN_PART_LOG2),
        .CODE_W   (CODE_W)
    ) u_stopcfg (
        .clk       (clk),
        .rst       (rst),
        .sp_set    (sp_set),
        .sp_code   (sp_code),
        .opt_reset (opt_reset),
        .part_mask (part_mask)
    );

    ssr_ptr #(
        .AW (AW)
    ) u_ptr (
        .clk            (clk),
        .rst            (rst),
        .xfer           (xfer),
        .xfer_addr      (xfer_addr),
        .step           (sc_step),
        .part_mask      (part_mask),
        .ptr_q          (ptr_q),
        .qsf_q          (qsf_q),
        .rd_fire        (rd_fire),
        .split_fire     (split_fire),
        .split_dst_half (split_dst_half)
    );

    ssr_store #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .load_full  (xfer == XF_FULL),
        .load_split (split_fire),
        .dst_half   (split_dst_half),
        .src_half   (xfer_addr[AW-1]),
        .row_bus    (row_bus),
        .rd_fire    (rd_fire),
        .rd_addr    (ptr_q),
        .word_q     (word_q)
    );

    assign sq_oe   = ~se_n;
    assign qsf_oe  = ~se_n;
    assign sq_out  = se_n ? '0 : word_q;
    assign qsf_out = ~se_n & qsf_q;

    // R10
    full_drops_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_full && sc_step) |=> $stable(word_q));

    // R9
    enable_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (se_n && !sc_step && !xfer_full && !xfer_split) |=> ($stable(ptr_q) && $stable(word_q)));

    // R3
    idle_holds_word_chk: assert property (@(posedge clk) disable iff (rst)
        !sc_step |=> $stable(word_q));

endmodule

// File: tb/ssr_ctrl_bench.sv
module ssr_ctrl_bench;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          xfer_full = 1'b0;
    logic          xfer_split = 1'b0;
    logic [8:0]    xfer_addr = '0;
    logic [8191:0] row_bus = '0;
    logic          sp_set = 1'b0;
    logic [1:0]    sp_code = '0;
    logic          opt_reset = 1'b0;
    logic          sc_step = 1'b0;
    logic          se_n = 1'b0;
    logic [15:0]   sq_out;
    logic          sq_oe;
    logic          qsf_out;
    logic          qsf_oe;

    always #4 clk = ~clk;

    ssr_ctrl u_ssr_ctrl (
        .clk        (clk),
        .rst        (rst),
        .xfer_full  (xfer_full),
        .xfer_split (xfer_split),
        .xfer_addr  (xfer_addr),
        .row_bus    (row_bus),
        .sp_set     (sp_set),
        .sp_code    (sp_code),
        .opt_reset  (opt_reset),
        .sc_step    (sc_step),
        .se_n       (se_n),
        .sq_out     (sq_out),
        .sq_oe      (sq_oe),
        .qsf_out    (qsf_out),
        .qsf_oe     (qsf_oe)
    );

    // Behavioural reference state
    logic [15:0] m_mem [512];
    logic [15:0] m_row [512];
    logic [15:0] m_word;
    int          m_ptr, m_pend, m_qsf, m_len;
    int          n_cmp = 0, n_bad = 0, cyc = 0;
    bit          done = 0;
    string       cur_req = "R1";

    task automatic make_row(input int seed);
        for (int i = 0; i < 512; i++) begin
            m_row[i] = 16'(seed * 7919 + i * 131 + (i >> 3) * 17);
            row_bus[i*16 +: 16] = m_row[i];
        end
    endtask

    task automatic model_update();
        int oldlen;
        int dst;
        int src;
        if (rst) begin
            for (int i = 0; i < 512; i++) m_mem[i] = '0;
            m_ptr = 0; m_pend = -1; m_qsf = 0; m_len = 256; m_word = '0;
            return;
        end
        oldlen = m_len;
        if (opt_reset) m_len = 256;
        else if (sp_set) m_len = 32 << sp_code;
        if (xfer_full) begin
            for (int i = 0; i < 512; i++) m_mem[i] = m_row[i];
            m_ptr  = int'(xfer_addr);
            m_pend = -1;
            m_qsf  = m_ptr / 256;
        end else begin
            if (sc_step) begin
                m_word = m_mem[m_ptr];
                if (((m_ptr % 256) % oldlen) == oldlen - 1 && m_pend >= 0) begin
                    m_ptr  = m_pend;
                    m_pend = -1;
                end else begin
                    m_ptr = (m_ptr + 1) % 512;
                end
                m_qsf = m_ptr / 256;
            end
            if (xfer_split) begin
                dst = 1 - m_ptr / 256;
                src = int'(xfer_addr) / 256;
                for (int i = 0; i < 256; i++) m_mem[dst*256 + i] = m_row[src*256 + i];
                m_pend = dst * 256 + int'(xfer_addr) % 256;
            end
        end
    endtask

    task automatic compare();
        logic [15:0] e_sq;
        logic        e_oe, e_qsf;
        e_oe  = !se_n;
        e_sq  = se_n ? 16'h0 : m_word;
        e_qsf = se_n ? 1'b0 : 1'(m_qsf);
        n_cmp++;
        if (sq_out !== e_sq || sq_oe !== e_oe || qsf_out !== e_qsf || qsf_oe !== e_oe) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual sq=%h oe=%b qsf=%b qoe=%b expected sq=%h oe=%b qsf=%b qoe=%b",
                     cur_req, cyc, sq_out, sq_oe, qsf_out, qsf_oe, e_sq, e_oe, e_qsf, e_oe);
        end
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(posedge clk);
            model_update();
            cyc++;
            @(negedge clk);
            compare();
        end
    endtask

    task automatic clear_cmds();
        xfer_full = 0; xfer_split = 0; sp_set = 0; opt_reset = 0; sc_step = 0;
    endtask

    task automatic do_full(input int addr, input int seed, input bit with_step);
        make_row(seed);
        xfer_addr = 9'(addr); xfer_full = 1; sc_step = with_step;
        run(1);
        clear_cmds();
    endtask

    task automatic do_split(input int addr, input int seed, input bit with_step);
        make_row(seed);
        xfer_addr = 9'(addr); xfer_split = 1; sc_step = with_step;
        run(1);
        clear_cmds();
    endtask

    task automatic do_stop(input int code, input bit orst);
        sp_code = 2'(code); sp_set = 1; opt_reset = orst;
        run(1);
        clear_cmds();
    endtask

    task automatic steps(input int n);
        sc_step = 1;
        run(n);
        sc_step = 0;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        run(3);
        rst = 0;
        run(2);

        // R2: full load sets tap and status; word held until a step
        cur_req = "R2";
        do_full(250, 1, 0);
        run(2);

        // R3 and R6: stepping from the tap across the half boundary
        cur_req = "R6";
        steps(12);
        cur_req = "R3";
        do_full(508, 2, 0);
        steps(8);

        // R4 then R5: split refill of upper half, jump at word 255
        cur_req = "R4";
        do_full(240, 3, 0);
        do_split(9'h010, 4, 0);
        run(2);
        cur_req = "R5";
        steps(25);

        // R7: 32-word partitions, jumps at 31 and at 287
        cur_req = "R7";
        do_stop(0, 0);
        do_full(20, 5, 0);
        do_split(5, 6, 0);
        steps(15);
        do_split(200, 7, 0);
        steps(40);
        do_stop(1, 0);
        do_split(300, 8, 0);
        steps(70);

        // R8: option reset beats stop-point set
        cur_req = "R8";
        do_stop(0, 1);
        do_full(20, 9, 0);
        do_split(9, 10, 0);
        steps(20);

        // R9: serial enable gates only the outputs
        cur_req = "R9";
        se_n = 1;
        steps(10);
        se_n = 0;
        run(2);
        steps(3);

        // R10: full load with a step, then full load with a split
        cur_req = "R10";
        do_full(100, 11, 1);
        run(1);
        make_row(12);
        xfer_addr = 9'd130; xfer_full = 1; xfer_split = 1;
        run(1);
        clear_cmds();
        steps(300);

        // R11: step and split load together at word 255
        cur_req = "R11";
        do_full(254, 13, 0);
        steps(1);
        do_split(9'h105, 14, 1);
        steps(260);

        // Mixed random traffic, every cycle compared against the model
        cur_req = "R6";
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            xfer_full  = (r < 2);
            xfer_split = (r >= 2 && r < 6);
            sp_set     = (int'($urandom_range(0, 99)) < 3);
            opt_reset  = (int'($urandom_range(0, 99)) < 1);
            sp_code    = 2'($urandom_range(0, 3));
            sc_step    = (int'($urandom_range(0, 99)) < 65);
            se_n       = (int'($urandom_range(0, 99)) < 10);
            xfer_addr  = 9'($urandom_range(0, 511));
            if (xfer_full || xfer_split) make_row(int'($urandom_range(1, 60000)));
            run(1);
        end
        clear_cmds();
        se_n = 0;
        run(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL %s watchdog: actual=still running expected=finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule